// File: doc/BRIEF.md
# Streaming MAC Protocol Sequencer

This block is the control sequencer for a byte-wide streaming dot-product engine. A host drives two 8-bit buses once per enabled clock. The sequencer counts the protocol steps. In the first step it captures the per-block settings: multiply mode, rounding, overflow behaviour, packing, the extended-mantissa flag, per-operand exponent offsets or a shared format, and a debug probe selector. In the next two steps it captures the scale byte, the element format and the block-max element index for operand A and then for operand B.

After the configuration steps it strobes element-valid for each element pair. It then raises one flush strobe and one final-scaling strobe. Last, it sends the 32-bit result from the datapath out on the output bus, one byte per step with the most significant byte first. A fast start skips the two scale steps and keeps the scales already stored. Packed mode halves the element phase. Loopback returns the XOR of the two buses. Debug mode shows a selected probe byte during the silent steps and an echo of the captured settings in the flush step.

The arithmetic datapath is not part of this block. Its 32-bit result and 8-bit probe arrive as inputs.

Top module: `mac_seq_ctrl`

## Requirements
- R1: While reset is low, the step counter and every captured register are zero. With both buses at zero, `dout` is zero and all strobes are low.
- R2: A standard block starts in step 0 with `bus_a[7]`=0 and visits steps 0,1,2,...,40. `elem_valid` is high in steps 3–34 only, `flush_go` is high in step 35 only and `scale_go` is high in step 36 only. After step 40 the counter returns to 0.
- R3: In step 1, `bus_a` becomes `scale_a`, `bus_b[2:0]` becomes `fmt_a` and `bus_b[7:3]` becomes `bmi_a`. Step 2 loads `scale_b`, `fmt_b` and `bmi_b` from the same bit positions.
- R4: In the four steps after the final-scaling step, `dout` carries `result_in[31:24]`, then `[23:16]`, then `[15:8]`, then `[7:0]`.
- R5: If `bus_a[7]`=1 in step 0, the next step is 3. `scale_a`, `scale_b`, `bmi_a`, `bmi_b`, `offs_a` and `offs_b` keep their values, and both `fmt_a` and `fmt_b` take `bus_b[2:0]`.
- R6: If `bus_a[7]`=0 in step 0, `offs_a` takes `bus_a[2:0]` and `offs_b` takes `bus_b[2:0]`.
- R7: Step 0 captures the following fields on both entry paths.
  - From `bus_a`: `mul_mode` from bits 4:3 (0 normal, 1 logarithmic, 2 hybrid), loopback from bit 5 and debug from bit 6.
  - From `bus_b`: `rnd_mode` from bits 4:3, `ovf_wrap` from bit 5, `pack_en` from bit 6 and `xmant_en` from bit 7.
- R8: With `pack_en` captured as 1, `elem_valid` is high in steps 3–18 only, flush comes in step 19, final scaling in step 20 and the result bytes in steps 21–24. After step 24 the counter returns to 0.
- R9: While loopback is active, `dout` equals `bus_a ^ bus_b`. In step 0 loopback is active when the live `bus_a[5]` is 1. In later steps it is active when the captured loopback bit is 1.
- R10: While debug is active, `dout` equals `probe_in` from step 0 through the last element step. In step 0 debug is active when the live `bus_a[6]` is 1. In step 0 `probe_sel` shows the live `bus_b[3:0]`, and afterwards it shows the captured value.
- R11: With debug active, `dout` in the flush step is an echo byte: bit 7 extended-mantissa, bit 6 packed, bit 5 overflow, bits 4:3 rounding, bits 2:1 multiply mode, bit 0 fast start. With debug inactive and loopback off, `dout` is zero in every step before the result bytes.
- R12: While `en` is low, the step counter and every captured register hold, whatever the buses carry, and `elem_valid`, `flush_go` and `scale_go` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Step enable; the sequencer advances only while high |
| bus_a | input | 8 | First host bus: step-0 settings, scale A, then elements |
| bus_b | input | 8 | Second host bus: step-0 settings, formats and indices, then elements |
| result_in | input | 32 | Accumulated result from the datapath |
| probe_in | input | 8 | Debug probe byte from the datapath |
| dout | output | 8 | Host output byte |
| seq_step | output | 6 | Current protocol step |
| elem_valid | output | 1 | Element pair on the buses is valid this step |
| flush_go | output | 1 | Pipeline flush step |
| scale_go | output | 1 | Final shared-scaling step |
| scale_a | output | 8 | Stored scale of operand A |
| scale_b | output | 8 | Stored scale of operand B |
| fmt_a | output | 3 | Element format of operand A |
| fmt_b | output | 3 | Element format of operand B |
| offs_a | output | 3 | Exponent offset of operand A |
| offs_b | output | 3 | Exponent offset of operand B |
| bmi_a | output | 5 | Block-max element index of operand A |
| bmi_b | output | 5 | Block-max element index of operand B |
| mul_mode | output | 2 | Multiply mode |
| rnd_mode | output | 2 | Rounding mode |
| ovf_wrap | output | 1 | Overflow mode: 1 wraps, 0 saturates |
| pack_en | output | 1 | Packed short sequence selected |
| xmant_en | output | 1 | Extended-mantissa enable |
| probe_sel | output | 4 | Debug probe selector for the datapath |

## Verification
The bench runs one block on each entry path. A design that reads the fast-start bit wrongly would land on step 1, or it would overwrite the stored scales and offsets. Packed blocks check where the element phase ends and where the counter wraps. A sequencer that shortened only the element phase would send the result bytes too late and run to step 40. Loopback and debug are decided from the live bus in step 0 and from the captured bits afterwards, and the bench drives blocks that exercise both sources. A design that used only the captured bits would show the wrong byte in step 0. An enable-low gap in the middle of the scale steps must leave the counter and the scale registers untouched and keep the strobes quiet.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

   localparam int FMT_W  = 3;
   localparam int OFFS_W = 3;
   localparam int BMI_W  = 5;
   localparam int MODE_W = 2;
   localparam int PSEL_W = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CFG,
      PH_STREAM,
      PH_FLUSH,
      PH_SCALE,
      PH_DRAIN
   } seq_phase_e;

   typedef struct packed {
      logic              xmant;
      logic              pk;
      logic              ovf;
      logic [MODE_W-1:0] rnd;
      logic [MODE_W-1:0] mul;
      logic              fast;
      logic              dbg;
      logic              lb;
      logic [PSEL_W-1:0] psel;
   } blk_meta_t;

   function automatic logic [7:0] meta_echo(input blk_meta_t m);
      return {m.xmant, m.pk, m.ovf, m.rnd, m.mul, m.fast};
   endfunction

endpackage

// File: rtl/mac_seq_counter.sv
module mac_seq_counter
   import mac_seq_pkg::*;
#(
   parameter int BLOCK_LEN = 32,
   parameter int PACK      = 2,
   parameter int NBYTES    = 4,
   parameter int STEP_W    = 6,
   parameter int IDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fast_go,
   input  logic              pk_sel,
   output logic [STEP_W-1:0] step,
   output seq_phase_e        phase,
   output logic [IDX_W-1:0]  byte_idx
);

   localparam int FIRST_EL = 3;
   localparam int SEND_STD = FIRST_EL + BLOCK_LEN - 1;
   localparam int SEND_PK  = FIRST_EL + BLOCK_LEN / PACK - 1;

   logic [STEP_W-1:0] send_at;
   logic [STEP_W-1:0] flush_at;
   logic [STEP_W-1:0] scale_at;
   logic [STEP_W-1:0] last_at;

   generate
      if (PACK > 1) begin : g_pack
         always_comb send_at = pk_sel ? STEP_W'(SEND_PK) : STEP_W'(SEND_STD);
      end else begin : g_nopack
         logic unused_pk;
         assign unused_pk = pk_sel;
         always_comb send_at = STEP_W'(SEND_STD);
      end
   endgenerate

   assign flush_at = send_at + STEP_W'(1);
   assign scale_at = send_at + STEP_W'(2);
   assign last_at  = send_at + STEP_W'(2 + NBYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (en) begin
         if (step == '0)
            step <= fast_go ? STEP_W'(FIRST_EL) : STEP_W'(1);
         else if (step == last_at)
            step <= '0;
         else
            step <= step + STEP_W'(1);
      end
   end

   always_comb begin
      if (step == '0)
         phase = PH_IDLE;
      else if (step < STEP_W'(FIRST_EL))
         phase = PH_CFG;
      else if (step <= send_at)
         phase = PH_STREAM;
      else if (step == flush_at)
         phase = PH_FLUSH;
      else if (step == scale_at)
         phase = PH_SCALE;
      else
         phase = PH_DRAIN;
   end

   assign byte_idx = IDX_W'(step - scale_at - STEP_W'(1));

endmodule

// File: rtl/mac_seq_capture.sv
module mac_seq_capture
   import mac_seq_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int STEP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [STEP_W-1:0] step,
   input  logic [BUS_W-1:0]  bus_a,
   input  logic [BUS_W-1:0]  bus_b,
   output blk_meta_t         meta,
   output logic [BUS_W-1:0]  scale_a,
   output logic [BUS_W-1:0]  scale_b,
   output logic [FMT_W-1:0]  fmt_a,
   output logic [FMT_W-1:0]  fmt_b,
   output logic [OFFS_W-1:0] offs_a,
   output logic [OFFS_W-1:0] offs_b,
   output logic [BMI_W-1:0]  bmi_a,
   output logic [BMI_W-1:0]  bmi_b
);

   logic at_meta, at_opa, at_opb;
   assign at_meta = en && (step == STEP_W'(0));
   assign at_opa  = en && (step == STEP_W'(1));
   assign at_opb  = en && (step == STEP_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
      end else if (at_meta) begin
         meta.psel  <= bus_b[3:0];
         meta.lb    <= bus_a[5];
         meta.dbg   <= bus_a[6];
         meta.fast  <= bus_a[7];
         meta.mul   <= bus_a[4:3];
         meta.rnd   <= bus_b[4:3];
         meta.ovf   <= bus_b[5];
         meta.pk    <= bus_b[6];
         meta.xmant <= bus_b[7];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offs_a <= '0;
         offs_b <= '0;
      end else if (at_meta && !bus_a[7]) begin
         offs_a <= bus_a[OFFS_W-1:0];
         offs_b <= bus_b[OFFS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_a <= '0;
         fmt_a   <= '0;
         bmi_a   <= '0;
      end else if (at_opa) begin
         scale_a <= bus_a;
         fmt_a   <= bus_b[FMT_W-1:0];
         bmi_a   <= bus_b[BUS_W-1 -: BMI_W];
      end else if (at_meta && bus_a[7]) begin
         fmt_a   <= bus_b[FMT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_b <= '0;
         fmt_b   <= '0;
         bmi_b   <= '0;
      end else if (at_opb) begin
         scale_b <= bus_a;
         fmt_b   <= bus_b[FMT_W-1:0];
         bmi_b   <= bus_b[BUS_W-1 -: BMI_W];
      end else if (at_meta && bus_a[7]) begin
         fmt_b   <= bus_b[FMT_W-1:0];
      end
   end

endmodule

// File: rtl/mac_seq_outmux.sv
module mac_seq_outmux
   import mac_seq_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int RES_W        = 32,
   parameter int NBYTES       = 4,
   parameter int IDX_W        = 2,
   parameter bit HAS_LOOPBACK = 1'b1,
   parameter bit HAS_DEBUG    = 1'b1
) (
   input  seq_phase_e       phase,
   input  logic [IDX_W-1:0] byte_idx,
   input  logic             lb_now,
   input  logic             dbg_now,
   input  logic [BUS_W-1:0] bus_a,
   input  logic [BUS_W-1:0] bus_b,
   input  logic [BUS_W-1:0] probe_in,
   input  logic [BUS_W-1:0] echo,
   input  logic [RES_W-1:0] result_in,
   output logic [BUS_W-1:0] dout
);

   logic [BUS_W-1:0] res_bytes [NBYTES];
   logic [BUS_W-1:0] core_byte;
   logic [BUS_W-1:0] dbg_byte;

   genvar g;
   generate
      for (g = 0; g < NBYTES; g++) begin : g_slice
         assign res_bytes[g] = result_in[RES_W-1-g*BUS_W -: BUS_W];
      end

      if (HAS_DEBUG) begin : g_dbg
         always_comb begin
            dbg_byte = '0;
            if (dbg_now) begin
               if (phase == PH_IDLE || phase == PH_CFG || phase == PH_STREAM)
                  dbg_byte = probe_in;
               else if (phase == PH_FLUSH)
                  dbg_byte = echo;
            end
         end
      end else begin : g_nodbg
         logic unused_dbg;
         assign unused_dbg = dbg_now ^ (^probe_in) ^ (^echo);
         assign dbg_byte = '0;
      end
   endgenerate

   always_comb begin
      if (phase == PH_DRAIN)
         core_byte = res_bytes[byte_idx];
      else
         core_byte = dbg_byte;
   end

   generate
      if (HAS_LOOPBACK) begin : g_lb
         assign dout = lb_now ? (bus_a ^ bus_b) : core_byte;
      end else begin : g_nolb
         logic unused_lb;
         assign unused_lb = lb_now ^ (^bus_a) ^ (^bus_b);
         assign dout = core_byte;
      end
   endgenerate

endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
   import mac_seq_pkg::*;
#(
   parameter int BUS_W        = 8,
   parameter int RES_W        = 32,
   parameter int BLOCK_LEN    = 32,
   parameter int PACK         = 2,
   parameter bit HAS_LOOPBACK = 1'b1,
   parameter bit HAS_DEBUG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [BUS_W-1:0]  bus_a,
   input  logic [BUS_W-1:0]  bus_b,
   input  logic [RES_W-1:0]  result_in,
   input  logic [BUS_W-1:0]  probe_in,
   output logic [BUS_W-1:0]  dout,
   output logic [5:0]        seq_step,
   output logic              elem_valid,
   output logic              flush_go,
   output logic              scale_go,
   output logic [BUS_W-1:0]  scale_a,
   output logic [BUS_W-1:0]  scale_b,
   output logic [2:0]        fmt_a,
   output logic [2:0]        fmt_b,
   output logic [2:0]        offs_a,
   output logic [2:0]        offs_b,
   output logic [4:0]        bmi_a,
   output logic [4:0]        bmi_b,
   output logic [1:0]        mul_mode,
   output logic [1:0]        rnd_mode,
   output logic              ovf_wrap,
   output logic              pack_en,
   output logic              xmant_en,
   output logic [3:0]        probe_sel
);

   localparam int NBYTES   = RES_W / BUS_W;
   localparam int IDX_W    = $clog2(NBYTES);
   localparam int LAST_STD = 3 + BLOCK_LEN + 1 + NBYTES;
   localparam int STEP_W   = $clog2(LAST_STD + 1);

   generate
      if (BUS_W != 8) begin : g_bad_bus
         $error("mac_seq_ctrl: field layout needs an 8-bit bus");
      end
      if (RES_W % BUS_W != 0 || NBYTES < 2) begin : g_bad_res
         $error("mac_seq_ctrl: result must be a whole number of bytes, at least two");
      end
      if (PACK < 1 || BLOCK_LEN % PACK != 0) begin : g_bad_pack
         $error("mac_seq_ctrl: block length must divide by the packing factor");
      end
      if (STEP_W != 6) begin : g_bad_step
         $error("mac_seq_ctrl: step port is 6 bits wide");
      end
   endgenerate

   blk_meta_t         meta;
   seq_phase_e        phase;
   logic [IDX_W-1:0]  byte_idx;
   logic [STEP_W-1:0] step;
   logic              step_zero;
   logic              lb_now;
   logic              dbg_now;

   mac_seq_counter #(
      .BLOCK_LEN (BLOCK_LEN),
      .PACK      (PACK),
      .NBYTES    (NBYTES),
      .STEP_W    (STEP_W),
      .IDX_W     (IDX_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .fast_go  (bus_a[7]),
      .pk_sel   (meta.pk),
      .step     (step),
      .phase    (phase),
      .byte_idx (byte_idx)
   );

   mac_seq_capture #(
      .BUS_W  (BUS_W),
      .STEP_W (STEP_W)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .step    (step),
      .bus_a   (bus_a),
      .bus_b   (bus_b),
      .meta    (meta),
      .scale_a (scale_a),
      .scale_b (scale_b),
      .fmt_a   (fmt_a),
      .fmt_b   (fmt_b),
      .offs_a  (offs_a),
      .offs_b  (offs_b),
      .bmi_a   (bmi_a),
      .bmi_b   (bmi_b)
   );

   assign step_zero = (step == '0);
   assign lb_now    = step_zero ? bus_a[5] : meta.lb;
   assign dbg_now   = step_zero ? bus_a[6] : meta.dbg;

   mac_seq_outmux #(
      .BUS_W        (BUS_W),
      .RES_W        (RES_W),
      .NBYTES       (NBYTES),
      .IDX_W        (IDX_W),
      .HAS_LOOPBACK (HAS_LOOPBACK),
      .HAS_DEBUG    (HAS_DEBUG)
   ) u_mux (
      .phase     (phase),
      .byte_idx  (byte_idx),
      .lb_now    (lb_now),
      .dbg_now   (dbg_now),
      .bus_a     (bus_a),
      .bus_b     (bus_b),
      .probe_in  (probe_in),
      .echo      (meta_echo(meta)),
      .result_in (result_in),
      .dout      (dout)
   );

   assign seq_step   = step;
   assign elem_valid = en && (phase == PH_STREAM);
   assign flush_go   = en && (phase == PH_FLUSH);
   assign scale_go   = en && (phase == PH_SCALE);
   assign mul_mode   = meta.mul;
   assign rnd_mode   = meta.rnd;
   assign ovf_wrap   = meta.ovf;
   assign pack_en    = meta.pk;
   assign xmant_en   = meta.xmant;
   assign probe_sel  = step_zero ? bus_b[3:0] : meta.psel;

endmodule

// File: rtl/mac_seq_ctrl_chk.sv
module mac_seq_ctrl_chk #(
   parameter int BLOCK_LEN = 32,
   parameter int PACK      = 2,
   parameter int NBYTES    = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic [7:0] bus_a,
   input logic [7:0] bus_b,
   input logic [7:0] dout,
   input logic [5:0] seq_step,
   input logic       elem_valid,
   input logic       flush_go,
   input logic       scale_go,
   input logic [7:0] scale_a,
   input logic [7:0] scale_b,
   input logic       pack_en
);

   localparam int SEND_STD = 2 + BLOCK_LEN;
   localparam int LAST_STD = SEND_STD + 2 + NBYTES;
   localparam int LAST_PK  = 2 + BLOCK_LEN / PACK + 2 + NBYTES;

   // R2
   std_to_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && seq_step == 6'd0 && !bus_a[7]) |=> seq_step == 6'd1);

   // R5
   fast_to_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && seq_step == 6'd0 && bus_a[7]) |=> seq_step == 6'd3);

   // R5
   fast_keeps_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && seq_step == 6'd0 && bus_a[7]) |=> ($stable(scale_a) && $stable(scale_b)));

   // R12
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(seq_step) && $stable(scale_a) && $stable(scale_b)));

   // R12
   strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!elem_valid && !flush_go && !scale_go));

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({elem_valid, flush_go, scale_go}));

   // R2
   stream_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid |-> (seq_step >= 6'd3 && seq_step <= 6'(SEND_STD)));

   // R2
   std_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !pack_en && seq_step == 6'(LAST_STD)) |=> seq_step == 6'd0);

   // R8
   pk_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pack_en && seq_step == 6'(LAST_PK)) |=> seq_step == 6'd0);

   // R9
   live_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_step == 6'd0 && bus_a[5]) |-> dout == (bus_a ^ bus_b));

endmodule

bind mac_seq_ctrl mac_seq_ctrl_chk #(
   .BLOCK_LEN (BLOCK_LEN),
   .PACK      (PACK),
   .NBYTES    (RES_W / BUS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .bus_a      (bus_a),
   .bus_b      (bus_b),
   .dout       (dout),
   .seq_step   (seq_step),
   .elem_valid (elem_valid),
   .flush_go   (flush_go),
   .scale_go   (scale_go),
   .scale_a    (scale_a),
   .scale_b    (scale_b),
   .pack_en    (pack_en)
);

// File: tb/mac_seq_ctrl_test.sv
module mac_seq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RES   = 32'hC3A5_1E96;
   localparam logic [7:0]  PROBE = 8'h5C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b1;
   logic [7:0]  bus_a = '0;
   logic [7:0]  bus_b = '0;
   logic [31:0] result_in = RES;
   logic [7:0]  probe_in = PROBE;
   logic [7:0]  dout;
   logic [5:0]  seq_step;
   logic        elem_valid, flush_go, scale_go;
   logic [7:0]  scale_a, scale_b;
   logic [2:0]  fmt_a, fmt_b, offs_a, offs_b;
   logic [4:0]  bmi_a, bmi_b;
   logic [1:0]  mul_mode, rnd_mode;
   logic        ovf_wrap, pack_en, xmant_en;
   logic [3:0]  probe_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .en(en), .bus_a(bus_a), .bus_b(bus_b),
      .result_in(result_in), .probe_in(probe_in), .dout(dout),
      .seq_step(seq_step), .elem_valid(elem_valid), .flush_go(flush_go),
      .scale_go(scale_go), .scale_a(scale_a), .scale_b(scale_b),
      .fmt_a(fmt_a), .fmt_b(fmt_b), .offs_a(offs_a), .offs_b(offs_b),
      .bmi_a(bmi_a), .bmi_b(bmi_b), .mul_mode(mul_mode), .rnd_mode(rnd_mode),
      .ovf_wrap(ovf_wrap), .pack_en(pack_en), .xmant_en(xmant_en),
      .probe_sel(probe_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [7:0] a, input logic [7:0] b);
      bus_a = a;
      bus_b = b;
      #1;
   endtask

   task automatic step0(input logic [7:0] a, input logic [7:0] b, input logic [7:0] exp, input string req);
      drive(a, b);
      chk({req, " step0 dout"}, dout, exp);
      tick();
   endtask

   task automatic cfg(input logic [7:0] a, input logic [7:0] b, input logic [7:0] exp, input string req);
      drive(a, b);
      chk({req, " cfg dout"}, dout, exp);
      tick();
   endtask

   task automatic walk(input bit pk, input bit dbg, input bit lb, input logic [7:0] echo);
      int send;
      int last;
      send = pk ? 18 : 34;
      last = send + 6;
      for (int c = 3; c <= last; c++) begin
         logic [7:0] a;
         logic [7:0] b;
         logic [7:0] exp;
         string tag;
         a = 8'(c * 3);
         b = 8'(c + 64);
         if (lb) begin
            exp = a ^ b; tag = "R9";
         end else if (c >= send + 3) begin
            exp = RES[(last - c) * 8 +: 8]; tag = "R4";
         end else if (dbg && c <= send) begin
            exp = PROBE; tag = "R10";
         end else if (dbg && c == send + 1) begin
            exp = echo; tag = "R11";
         end else begin
            exp = 8'h00; tag = "R11";
         end
         drive(a, b);
         chk(pk ? "R8 step" : "R2 step", 32'(seq_step), 32'(c));
         chk(pk ? "R8 elem_valid" : "R2 elem_valid", 32'(elem_valid), 32'(c <= send));
         chk(pk ? "R8 flush" : "R2 flush", 32'(flush_go), 32'(c == send + 1));
         chk(pk ? "R8 scale" : "R2 scale", 32'(scale_go), 32'(c == send + 2));
         chk({tag, " dout"}, 32'(dout), 32'(exp));
         tick();
      end
      chk(pk ? "R8 wrap" : "R2 wrap", 32'(seq_step), 32'd0);
   endtask

   task automatic t_reset;
      drive(8'h00, 8'h00);
      chk("R1 step", 32'(seq_step), 32'd0);
      chk("R1 scale_a", 32'(scale_a), 32'd0);
      chk("R1 scale_b", 32'(scale_b), 32'd0);
      chk("R1 fmt", 32'({fmt_a, fmt_b, offs_a, offs_b}), 32'd0);
      chk("R1 modes", 32'({mul_mode, rnd_mode, ovf_wrap, pack_en, xmant_en}), 32'd0);
      chk("R1 dout", 32'(dout), 32'd0);
      chk("R1 strobes", 32'({elem_valid, flush_go, scale_go}), 32'd0);
   endtask

   task automatic t_standard;
      step0(8'h15, 8'hBB, 8'h00, "R11");
      chk("R2 step1", 32'(seq_step), 32'd1);
      chk("R6 offs_a", 32'(offs_a), 32'd5);
      chk("R6 offs_b", 32'(offs_b), 32'd3);
      chk("R7 mul_mode", 32'(mul_mode), 32'd2);
      chk("R7 rnd_mode", 32'(rnd_mode), 32'd3);
      chk("R7 ovf pack xmant", 32'({ovf_wrap, pack_en, xmant_en}), 32'b101);
      cfg(8'h85, 8'h9A, 8'h00, "R11");
      chk("R2 step2", 32'(seq_step), 32'd2);
      cfg(8'h7F, 8'h2C, 8'h00, "R11");
      chk("R3 scale_a", 32'(scale_a), 32'h85);
      chk("R3 fmt_a", 32'(fmt_a), 32'd2);
      chk("R3 bmi_a", 32'(bmi_a), 32'd19);
      chk("R3 scale_b", 32'(scale_b), 32'h7F);
      chk("R3 fmt_b", 32'(fmt_b), 32'd4);
      chk("R3 bmi_b", 32'(bmi_b), 32'd5);
      walk(1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic t_fast;
      step0(8'h88, 8'h0E, 8'h00, "R11");
      chk("R5 jump", 32'(seq_step), 32'd3);
      chk("R5 scales kept", 32'({scale_a, scale_b}), 32'h857F);
      chk("R5 bmi kept", 32'({bmi_a, bmi_b}), 32'({5'd19, 5'd5}));
      chk("R5 formats", 32'({fmt_a, fmt_b}), 32'({3'd6, 3'd6}));
      chk("R5 offsets kept", 32'({offs_a, offs_b}), 32'({3'd5, 3'd3}));
      chk("R7 fast modes", 32'({mul_mode, rnd_mode, ovf_wrap, xmant_en}), 32'b01_01_0_0);
      walk(1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic t_packed;
      step0(8'h00, 8'h40, 8'h00, "R11");
      chk("R7 pack_en", 32'(pack_en), 32'd1);
      cfg(8'h01, 8'h01, 8'h00, "R11");
      cfg(8'h02, 8'h02, 8'h00, "R11");
      walk(1'b1, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic t_debug;
      drive(8'h48, 8'h67);
      chk("R10 live probe_sel", 32'(probe_sel), 32'd7);
      chk("R10 step0 dout", 32'(dout), 32'(PROBE));
      tick();
      chk("R10 held probe_sel", 32'(probe_sel), 32'd7);
      cfg(8'h03, 8'h03, PROBE, "R10");
      cfg(8'h04, 8'h04, PROBE, "R10");
      walk(1'b1, 1'b1, 1'b0, 8'h62);
   endtask

   task automatic t_loopback;
      step0(8'h20, 8'h0F, 8'h2F, "R9");
      cfg(8'h10, 8'h31, 8'h21, "R9");
      cfg(8'h44, 8'h05, 8'h41, "R9");
      walk(1'b0, 1'b0, 1'b1, 8'h00);
   endtask

   task automatic t_enable;
      step0(8'h00, 8'h00, 8'h00, "R11");
      cfg(8'h11, 8'h21, 8'h00, "R11");
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         drive(8'hEE, 8'hFF);
         chk("R12 strobes low", 32'({elem_valid, flush_go, scale_go}), 32'd0);
         tick();
      end
      chk("R12 step held", 32'(seq_step), 32'd2);
      chk("R12 scale_b held", 32'(scale_b), 32'h44);
      chk("R12 scale_a held", 32'(scale_a), 32'h11);
      chk("R12 fmt_b held", 32'(fmt_b), 32'd5);
      en = 1'b1;
      cfg(8'h22, 8'h0B, 8'h00, "R11");
      chk("R3 scale_b after gap", 32'(scale_b), 32'h22);
      walk(1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      #1;
      t_standard();
      t_fast();
      t_packed();
      t_debug();
      t_loopback();
      t_enable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule